// File: doc/BRIEF.md
# Event-Driven Channel Hit Sequencer

This block is the digital controller for a multi-channel particle-detector front end. It watches two comparators on every channel: a fast one that marks arrival time and a slower energy one. The first hit seen while the block is idle opens an event and latches the current timestamp. Further hits join the event until the programmed delay ends. The delay is set to match the shaper's peaking time. The block then issues a one-cycle peak-hold sample strobe.

If the external validation input is high during that strobe, the block digitises the channels that were hit, together with their immediate neighbours. It serves them in ascending order, one at a time: it drives the analog multiplexer select, pulses the ADC start and waits for the ADC's done signal. Each result goes into a small show-ahead FIFO with the timestamp, the channel number and a bit that says which comparator produced the timestamp.

Valid or not, every event finishes with a reset phase. In this phase a fixed-length front-end reset and a peak-hold reset of programmable length are issued, and the event's digital state is cleared. A registered OR of all channel comparators is driven out as a chip-level trigger at all times.

Top module: `hit_sequencer`

## Requirements
- R1: While reset is applied, and after it is released: trig_or, ph_sample, fe_rst, ph_rst and adc_start are low, fifo_empty is high and fifo_ovf is low.
- R2: trig_or is high in the cycle after any bit of hit_fast or hit_energy was high, and low in the cycle after all were low, whatever the sequencer is doing.
- R3: An event opens at the clock edge that samples a hit while the sequencer is idle. Hits sampled in the edge that opens the event, and in the waiting cycles after it, join the event. ph_sample is high for exactly one cycle, starting cfg_sample_dly+1 cycles after the opening edge.
- R4: An event is digitised only if validate is high during its ph_sample cycle. Otherwise no adc_start occurs, nothing is written to the FIFO, and the reset phase begins in the next cycle.
- R5: The set of channels read out is every hit channel plus channels ch-1 and ch+1 of each hit channel, limited to 0..NCH-1 with no wrap-around.
- R6: The channels in the set are served in ascending order, each exactly once. For each one, mux_sel holds the channel number, adc_start pulses for one cycle, and the block waits for adc_done before going on to the next channel.
- R7: Each FIFO entry holds these fields: bits [34:20] the timestamp latched at the opening edge, bits [19:13] the channel, bits [12:1] the adc_data present with adc_done, and bit [0] the hit bit. The hit bit is 1 only if that channel's fast comparator was sampled high during the event window. It is 0 when the entry is energy-only or neighbour-only.
- R8: The reset phase begins after the last conversion, or after ph_sample for an invalid event. In this phase fe_rst is high for FE_RST_LEN cycles and ph_rst is high for cfg_phrst_len cycles; both start in the same cycle. Hits arriving during the reset phase do not start or extend an event.
- R9: A write to a full FIFO is dropped, and fifo_ovf goes high and stays high until reset.
- R10: fifo_data shows the oldest entry. A cycle with fifo_rd high and a non-empty FIFO removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_fast | input | 128 | Fast (timing) comparator per channel |
| hit_energy | input | 128 | Energy comparator per channel |
| validate | input | 1 | External event validation |
| ts_in | input | 15 | Running timestamp |
| cfg_sample_dly | input | 8 | Hit-to-sample delay setting |
| cfg_phrst_len | input | 8 | Peak-hold reset length in cycles |
| trig_or | output | 1 | Registered OR of all comparators |
| ph_sample | output | 1 | Peak-hold sample strobe |
| fe_rst | output | 1 | Preamplifier and shaper reset |
| ph_rst | output | 1 | Peak-hold reset |
| mux_sel | output | 7 | Analog multiplexer channel select |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion finished, adc_data valid |
| adc_data | input | 12 | Conversion result |
| fifo_rd | input | 1 | Remove head entry |
| fifo_data | output | 35 | Head entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_ovf | output | 1 | Sticky overflow flag |

## Verification
A corrupted delay counter shows at the ports within one event: ph_sample moves away from cfg_sample_dly+1 cycles, or fe_rst and ph_rst pulse for the wrong number of cycles. A wrong pending mask or a wrong priority pick shows as soon as the conversions start, as a missing, repeated or out-of-order mux_sel value at adc_start. A stale or wrongly captured hit map shows when the FIFO is drained, as a wrong timestamp, channel, data or hit bit. It can also show one event later, as a phantom ph_sample after a reset phase in which hits arrived.

// File: rtl/hseq_pkg.sv
package hseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_SAMPLE,
        S_SELECT,
        S_START,
        S_CONV,
        S_RESET
    } seq_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hseq_capture.sv
module hseq_capture #(
    parameter int NCH = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit_fast,
    input  logic [NCH-1:0] hit_energy,
    input  logic           capture_en,
    input  logic           clear,
    output logic [NCH-1:0] read_mask,
    output logic [NCH-1:0] fast_map,
    output logic           any_hit,
    output logic           trig_or
);

    typedef struct packed {
        logic [NCH-1:0] hit_map;
        logic [NCH-1:0] fast_map;
        logic           trig;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [NCH-1:0] hits_now;

    assign hits_now = hit_fast | hit_energy;
    assign any_hit  = |hits_now;

    always_comb begin
        cap_d      = cap_q;
        cap_d.trig = |hits_now;
        if (clear) begin
            cap_d.hit_map  = '0;
            cap_d.fast_map = '0;
        end else if (capture_en) begin
            cap_d.hit_map  = cap_q.hit_map | hits_now;
            cap_d.fast_map = cap_q.fast_map | hit_fast;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    // Neighbour expansion: each channel is read if it or an adjacent one was hit
    for (genvar i = 0; i < NCH; i++) begin : g_nb
        if (i == 0) begin : g_lo
            assign read_mask[i] = cap_q.hit_map[i] | cap_q.hit_map[i+1];
        end else if (i == NCH - 1) begin : g_hi
            assign read_mask[i] = cap_q.hit_map[i] | cap_q.hit_map[i-1];
        end else begin : g_mid
            assign read_mask[i] = cap_q.hit_map[i] | cap_q.hit_map[i-1] | cap_q.hit_map[i+1];
        end
    end

    assign fast_map = cap_q.fast_map;
    assign trig_or  = cap_q.trig;

    // R8
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !clear) |=> $stable(cap_q.hit_map));

endmodule

// File: rtl/hseq_picker.sv
module hseq_picker #(
    parameter int NCH  = 128,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    output logic [CH_W-1:0] idx,
    output logic            found
);

    // Lowest requesting channel wins
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) idx = CH_W'(i);
        end
    end

    assign found = |req;

endmodule

// File: rtl/hseq_fifo.sv
module hseq_fifo #(
    parameter int W     = 35,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
        logic                    ovf;
    } fifo_t;

    fifo_t f_d, f_q;
    logic  full, do_push, do_pop;

    assign full    = (f_q.cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (f_q.cnt != '0);

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        f_d = f_q;
        if (do_push) begin
            f_d.mem[f_q.wr] = wdata;
            f_d.wr          = step(f_q.wr);
        end
        if (do_pop) f_d.rd = step(f_q.rd);
        if (do_push && !do_pop)      f_d.cnt = f_q.cnt + CNT_W'(1);
        else if (do_pop && !do_push) f_d.cnt = f_q.cnt - CNT_W'(1);
        if (push && full) f_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rdata = f_q.mem[f_q.rd];
    assign empty = (f_q.cnt == '0);
    assign ovf   = f_q.ovf;

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.ovf |=> f_q.ovf);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> (f_q.ovf && $stable(f_q.cnt)));

endmodule

// File: rtl/hit_sequencer.sv
module hit_sequencer
    import hseq_pkg::*;
#(
    parameter int NCH        = 128,
    parameter int TS_W       = 15,
    parameter int ADC_W      = 12,
    parameter int DLY_W      = 8,
    parameter int PHR_W      = 8,
    parameter int FE_RST_LEN = 3,
    parameter int FIFO_DEPTH = 8,
    parameter int CH_W       = $clog2(NCH),
    parameter int ENTRY_W    = TS_W + CH_W + ADC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCH-1:0]     hit_fast,
    input  logic [NCH-1:0]     hit_energy,
    input  logic               validate,
    input  logic [TS_W-1:0]    ts_in,
    input  logic [DLY_W-1:0]   cfg_sample_dly,
    input  logic [PHR_W-1:0]   cfg_phrst_len,
    output logic               trig_or,
    output logic               ph_sample,
    output logic               fe_rst,
    output logic               ph_rst,
    output logic [CH_W-1:0]    mux_sel,
    output logic               adc_start,
    input  logic               adc_done,
    input  logic [ADC_W-1:0]   adc_data,
    input  logic               fifo_rd,
    output logic [ENTRY_W-1:0] fifo_data,
    output logic               fifo_empty,
    output logic               fifo_ovf
);

    localparam int CNT_W = max_of(max_of(DLY_W, PHR_W), $clog2(FE_RST_LEN + 1)) + 1;

    typedef struct packed {
        seq_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [TS_W-1:0]  ts;
        logic [CH_W-1:0]  ch;
        logic [NCH-1:0]   pending;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NCH-1:0]   read_mask, fast_map;
    logic             any_hit, capture_en, clear_maps;
    logic [CH_W-1:0]  pick_idx;
    logic             pick_found;
    logic [CNT_W-1:0] rst_span;
    logic             rst_last, push;
    logic [ENTRY_W-1:0] entry;

    hseq_capture #(.NCH(NCH)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_fast   (hit_fast),
        .hit_energy (hit_energy),
        .capture_en (capture_en),
        .clear      (clear_maps),
        .read_mask  (read_mask),
        .fast_map   (fast_map),
        .any_hit    (any_hit),
        .trig_or    (trig_or)
    );

    hseq_picker #(.NCH(NCH), .CH_W(CH_W)) u_picker (
        .req   (seq_q.pending),
        .idx   (pick_idx),
        .found (pick_found)
    );

    // Reset phase spans the longer of the two reset pulses, at least one cycle
    always_comb begin
        rst_span = CNT_W'(FE_RST_LEN);
        if (CNT_W'(cfg_phrst_len) > rst_span) rst_span = CNT_W'(cfg_phrst_len);
        if (rst_span == '0) rst_span = CNT_W'(1);
    end

    assign rst_last = (seq_q.state == S_RESET) && ((seq_q.cnt + CNT_W'(1)) >= rst_span);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            S_IDLE: begin
                if (any_hit) begin
                    seq_d.state = S_WAIT;
                    seq_d.cnt   = '0;
                    seq_d.ts    = ts_in;
                end
            end
            S_WAIT: begin
                if (seq_q.cnt == CNT_W'(cfg_sample_dly)) seq_d.state = S_SAMPLE;
                else                                     seq_d.cnt   = seq_q.cnt + CNT_W'(1);
            end
            S_SAMPLE: begin
                seq_d.cnt = '0;
                if (validate) begin
                    seq_d.pending = read_mask;
                    seq_d.state   = S_SELECT;
                end else begin
                    seq_d.state = S_RESET;
                end
            end
            S_SELECT: begin
                if (pick_found) begin
                    seq_d.ch    = pick_idx;
                    seq_d.state = S_START;
                end else begin
                    seq_d.cnt   = '0;
                    seq_d.state = S_RESET;
                end
            end
            S_START: seq_d.state = S_CONV;
            S_CONV: begin
                if (adc_done) begin
                    seq_d.pending[seq_q.ch] = 1'b0;
                    seq_d.state             = S_SELECT;
                end
            end
            S_RESET: begin
                if (rst_last) begin
                    seq_d.state = S_IDLE;
                    seq_d.cnt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign capture_en = (seq_q.state == S_IDLE) || (seq_q.state == S_WAIT);
    assign clear_maps = rst_last;
    assign ph_sample  = (seq_q.state == S_SAMPLE);
    assign adc_start  = (seq_q.state == S_START);
    assign fe_rst     = (seq_q.state == S_RESET) && (seq_q.cnt < CNT_W'(FE_RST_LEN));
    assign ph_rst     = (seq_q.state == S_RESET) && (seq_q.cnt < CNT_W'(cfg_phrst_len));
    assign mux_sel    = seq_q.ch;
    assign push       = (seq_q.state == S_CONV) && adc_done;
    assign entry      = {seq_q.ts, seq_q.ch, adc_data, fast_map[seq_q.ch]};

    hseq_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (entry),
        .pop   (fifo_rd),
        .rdata (fifo_data),
        .empty (fifo_empty),
        .ovf   (fifo_ovf)
    );

    // R3
    sample_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_sample |=> !ph_sample);

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R4
    invalid_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_sample && !validate) |=> (!adc_start && fe_rst));

    // R8
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_rst || ph_rst) |-> (!adc_start && !ph_sample));

endmodule

// File: tb/tb_hit_sequencer.sv
module tb_hit_sequencer;

    localparam int NCH = 128, TS_W = 15, ADC_W = 12, DLY_W = 8, PHR_W = 8;
    localparam int FE_RST_LEN = 3, FIFO_DEPTH = 8, CH_W = 7, ENTRY_W = 35;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NCH-1:0]     hit_fast = '0, hit_energy = '0;
    logic               validate = 1'b0;
    logic [TS_W-1:0]    ts_in = '0;
    logic [DLY_W-1:0]   cfg_sample_dly = '0;
    logic [PHR_W-1:0]   cfg_phrst_len = 8'd1;
    logic               trig_or, ph_sample, fe_rst, ph_rst, adc_start;
    logic [CH_W-1:0]    mux_sel;
    logic               adc_done = 1'b0;
    logic [ADC_W-1:0]   adc_data = '0;
    logic               fifo_rd = 1'b0;
    logic [ENTRY_W-1:0] fifo_data;
    logic               fifo_empty, fifo_ovf;

    int n_chk = 0, n_fail = 0;
    int adc_log[$];
    bit ovf_exp = 1'b0;

    always #2 clk = ~clk;

    hit_sequencer #(
        .NCH(NCH), .TS_W(TS_W), .ADC_W(ADC_W), .DLY_W(DLY_W), .PHR_W(PHR_W),
        .FE_RST_LEN(FE_RST_LEN), .FIFO_DEPTH(FIFO_DEPTH)
    ) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int adc_val(input int ch);
        return (ch * 53 + 11) % 4096;
    endfunction

    // ADC stub: answers each start after a fixed latency
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                adc_log.push_back(int'(mux_sel));
                repeat (2) @(negedge clk);
                adc_done = 1'b1;
                adc_data = ADC_W'(adc_val(int'(mux_sel)));
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    task automatic run_event(input logic [NCH-1:0] he, input logic [NCH-1:0] hf,
                             input logic [NCH-1:0] join_e, input int dly,
                             input int phl, input bit val, input bit poke);
        logic [NCH-1:0] hitall, mask;
        logic [TS_W-1:0] ts;
        int exp_list[$];
        int fe_n = 0, ph_n = 0, nstore;
        bit seen = 1'b0, poked = 1'b0;
        @(negedge clk);
        cfg_sample_dly = DLY_W'(dly);
        cfg_phrst_len  = PHR_W'(phl);
        validate       = val;
        adc_log.delete();
        ts          = TS_W'($urandom);
        ts_in       = ts;
        hit_energy  = he;
        hit_fast    = hf;
        for (int k = 0; k <= dly + 1; k++) begin
            @(negedge clk);
            if (k == 0) begin
                check(trig_or == |(he | hf), "R2", "trig after hit", trig_or, |(he | hf));
                hit_energy = join_e;
                hit_fast   = '0;
                ts_in      = TS_W'($urandom);
            end else if (k == 1) begin
                check(trig_or == |join_e, "R2", "trig after join", trig_or, |join_e);
                hit_energy = '0;
            end
            check(ph_sample == (k == dly + 1), "R3", $sformatf("ph_sample at k=%0d", k),
                  ph_sample, (k == dly + 1));
        end
        hit_energy = '0;
        hitall = he | hf | join_e;
        for (int c = 0; c < NCH; c++) begin
            mask[c] = hitall[c] | ((c > 0) && hitall[c-1]) | ((c < NCH - 1) && hitall[c+1]);
            if (mask[c] && val) exp_list.push_back(c);
        end
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (poked) begin
                hit_energy = '0;
                hit_fast   = '0;
            end
            if (fe_rst) fe_n++;
            if (ph_rst) ph_n++;
            if (fe_rst || ph_rst) begin
                if (poke && !poked) begin
                    hit_energy[40] = 1'b1;
                    hit_fast[41]   = 1'b1;
                    poked = 1'b1;
                end
                seen = 1'b1;
            end else if (seen) begin
                break;
            end
        end
        hit_energy = '0;
        hit_fast   = '0;
        check(fe_n == FE_RST_LEN, "R8", "fe_rst length", fe_n, FE_RST_LEN);
        check(ph_n == phl, "R8", "ph_rst length", ph_n, phl);
        check(adc_log.size() == exp_list.size(), val ? "R5" : "R4", "conversion count",
              adc_log.size(), exp_list.size());
        for (int i = 0; i < exp_list.size() && i < adc_log.size(); i++)
            check(adc_log[i] == exp_list[i], "R6", "conversion order", adc_log[i], exp_list[i]);
        if (poke) begin
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                check(!ph_sample && !adc_start, "R8", "hit during reset ignored",
                      ph_sample | adc_start, 0);
            end
        end
        nstore = (exp_list.size() > FIFO_DEPTH) ? FIFO_DEPTH : exp_list.size();
        if (exp_list.size() > FIFO_DEPTH) ovf_exp = 1'b1;
        check(fifo_ovf == ovf_exp, "R9", "overflow flag", fifo_ovf, ovf_exp);
        for (int i = 0; i < nstore; i++) begin
            check(!fifo_empty, "R10", "entry present", fifo_empty, 0);
            check(fifo_data[34:20] == ts, "R7", "timestamp field", fifo_data[34:20], ts);
            check(int'(fifo_data[19:13]) == exp_list[i], "R7", "channel field",
                  fifo_data[19:13], exp_list[i]);
            check(int'(fifo_data[12:1]) == adc_val(exp_list[i]), "R7", "data field",
                  fifo_data[12:1], adc_val(exp_list[i]));
            check(fifo_data[0] == hf[exp_list[i]], "R7", "hit bit",
                  fifo_data[0], hf[exp_list[i]]);
            fifo_rd = 1'b1;
            @(negedge clk);
            fifo_rd = 1'b0;
        end
        check(fifo_empty, "R10", "drained", fifo_empty, 1);
        validate = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NCH-1:0] he, hf, jn;
        int seed_dummy;
        seed_dummy = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        check(!trig_or && !ph_sample && !fe_rst && !ph_rst && !adc_start, "R1",
              "outputs in reset", {trig_or, ph_sample, fe_rst, ph_rst, adc_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fifo_empty && !fifo_ovf, "R1", "fifo after reset", {fifo_empty, fifo_ovf}, 2);
        check(!ph_sample && !fe_rst && !adc_start, "R1", "idle after reset",
              {ph_sample, fe_rst, adc_start}, 0);

        // Boundary channels, fast on the top one
        he = '0; hf = '0; he[0] = 1'b1; hf[127] = 1'b1;
        run_event(he, hf, '0, 3, 2, 1'b1, 1'b0);
        // Adjacent hits plus a join during the wait
        he = '0; hf = '0; jn = '0; he[6] = 1'b1; hf[5] = 1'b1; jn[7] = 1'b1;
        run_event(he, hf, jn, 0, 5, 1'b1, 1'b0);
        // Not validated
        he = '0; he[64] = 1'b1;
        run_event(he, '0, '0, 2, 4, 1'b0, 1'b0);
        // Hit arrives during the reset phase
        he = '0; hf = '0; hf[90] = 1'b1;
        run_event(he, hf, '0, 1, 6, 1'b1, 1'b1);

        for (int e = 0; e < 24; e++) begin
            int c1, c2;
            he = '0; hf = '0; jn = '0;
            c1 = $urandom % NCH;
            c2 = $urandom % NCH;
            he[c1] = 1'b1;
            if ($urandom % 2) hf[c1] = 1'b1;
            if ($urandom % 2) begin
                if ($urandom % 2) hf[c2] = 1'b1; else he[c2] = 1'b1;
            end else if ($urandom % 2) begin
                jn[c2] = 1'b1;
            end
            run_event(he, hf, jn, $urandom % 6, 1 + $urandom % 6, ($urandom % 4) != 0, 1'b0);
        end

        // Nine readouts into an eight-deep FIFO
        he = '0; hf = '0; he[10] = 1'b1; hf[20] = 1'b1; he[30] = 1'b1;
        run_event(he, hf, '0, 2, 3, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check(fifo_ovf, "R9", "overflow stays set", fifo_ovf, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule